// File: doc/BRIEF.md
# Three-Slot CEC Receive Frame Store

This block sits behind a bit-level CEC receiver and keeps up to three complete received frames until software has read them. Bytes arrive one per cycle on a byte-wide stream with a valid strobe, an end-of-frame marker and an error flag. The first byte of a frame is the header. Its low nibble is the destination address. The frame is kept only if that address is the broadcast address or matches one of three programmable logical-address slots that is switched on.

Each stored frame goes into a free slot. The block records how old each stored frame is as a 2-bit age code, and packs the codes into one order field so that software can drain the slots oldest first. Every slot raises its own ready interrupt while it holds a frame. Software frees a slot by writing its clear bit high and then low again. The codes of the younger frames then move down so that they stay dense. A mode bit chooses between using all three slots and using slot 0 only.

Reception is run by a three-state machine:
- **ST_IDLE** waits for a header byte. On an accepted header it goes to **ST_FILL**. On a rejected header that is not also the last byte it goes to **ST_SKIP**. A one-byte frame is stored, or dropped, without leaving ST_IDLE.
- **ST_FILL** stores data bytes. It returns to ST_IDLE on the last byte, committing the frame when there is no error. On a 17th byte it moves to ST_SKIP, or to ST_IDLE if that byte is the last one, and commits nothing.
- **ST_SKIP** discards bytes until the last byte and then returns to ST_IDLE.

Top module: `cec_rx_frame_store`

## Requirements
- R1: There are three slots, numbered 0 to 2. `ready_irq[i]` is high exactly while slot i holds a frame. It rises in the cycle after the clock edge that samples the last byte of an accepted, error-free frame.
- R2: `order_field` holds 2 bits per slot: slot 0 in [1:0], slot 1 in [3:2] and slot 2 in [5:4]. Code 0 means the slot is empty. Codes 1, 2 and 3 mark the oldest, second-oldest and third-oldest stored frame. A newly stored frame gets the code equal to the number of stored frames plus one.
- R3: A stored frame keeps its header at byte index 0 and its data bytes at indices 1 upward. Selecting the slot on `rd_buf` and the index on `rd_idx` shows the byte on `rd_byte`. `rd_len` gives, in 5 bits, the total byte count including the header. Frames of 1 to 16 bytes are stored.
- R4: A slot is freed when `buf_ctrl[i]` is sampled high and then sampled low at the next edge. The slot is freed at the edge that samples it low. Every stored frame with a higher code then has its code lowered by one. Toggling the clear bit of an empty slot has no effect.
- R5: `buf_ctrl[3]` = 1 allows all three slots. With `buf_ctrl[3]` = 0, only slot 0 receives frames.
- R6: A frame is accepted only if header bits [3:0] equal 15, or equal a slot `addr_list[4k+3:4k]` whose `addr_en[k]` is 1.
- R7: When no allowed slot is free, an incoming frame is dropped. The stored frames, their codes and their bytes stay unchanged.
- R8: A frame whose last byte carries `in_err`, or that is longer than 16 bytes, is discarded and raises no interrupt.
- R9: In three-slot mode, an accepted frame goes into the lowest-numbered empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte strobe from the bit receiver |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Error flag, taken into account with the final byte |
| buf_ctrl | input | 4 | [2:0] per-slot clear bits, [3] three-slot mode |
| addr_en | input | 3 | Enables for the three logical-address slots |
| addr_list | input | 12 | Three 4-bit logical addresses, slot k at [4k+3:4k] |
| rd_buf | input | 2 | Slot selected for reading |
| rd_idx | input | 4 | Byte index inside the selected slot |
| rd_byte | output | 8 | Byte at rd_idx of slot rd_buf (combinational) |
| rd_len | output | 5 | Stored length of slot rd_buf |
| order_field | output | 6 | Packed age codes |
| ready_irq | output | 3 | Per-slot ready interrupts |

## Verification
The order field, the interrupts and the stored length and bytes of a frame all change at the clock edge that samples the frame's last byte. The bench therefore checks them at the falling edge that follows that byte. A release takes effect at the edge that samples the clear bit low, and it is checked at the falling edge after that edge. The read port is combinational, so the bench changes `rd_buf` and `rd_idx` between clock edges and samples one time step later. A bench model that follows the requirements gives the expected value for every check, both in the directed corner cases and in the random frame and release traffic.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = 2;
    localparam int CODE_W    = 2;
    localparam int BYTE_W    = 8;
    localparam int LA_W      = 4;
    localparam logic [LA_W-1:0] BCAST_ADDR = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SKIP = 2'd2
    } rx_state_t;
endpackage

// File: rtl/cec_rx_addr_filter.sv
module cec_rx_addr_filter
    import cec_rx_pkg::*;
#(
    parameter int NUM_LA = 3
) (
    input  logic [LA_W-1:0]        dest,
    input  logic [NUM_LA-1:0]      la_en,
    input  logic [NUM_LA*LA_W-1:0] la_list,
    output logic                   hit
);
    logic [NUM_LA-1:0] slot_hit;

    for (genvar k = 0; k < NUM_LA; k++) begin : g_la
        assign slot_hit[k] = la_en[k] && (la_list[k*LA_W +: LA_W] == dest);
    end

    assign hit = (dest == BCAST_ADDR) || (|slot_hit);
endmodule

// File: rtl/cec_rx_order_track.sv
module cec_rx_order_track
    import cec_rx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [SLOT_W-1:0]             commit_slot,
    input  logic [NUM_SLOTS-1:0]          release_req,
    output logic [NUM_SLOTS*CODE_W-1:0]   order_field,
    output logic [NUM_SLOTS-1:0]          occupied
);
    logic [CODE_W-1:0] code_q [NUM_SLOTS];
    logic [CODE_W-1:0] code_d [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] freed;
    logic [CODE_W-1:0] held_cnt;
    logic [CODE_W-1:0] dec;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pack
        assign occupied[s] = (code_q[s] != '0);
        assign order_field[s*CODE_W +: CODE_W] = code_q[s];
    end

    assign freed = release_req & occupied;

    always_comb begin
        held_cnt = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (occupied[s] && !freed[s]) begin
                held_cnt = held_cnt + CODE_W'(1);
            end
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            dec = '0;
            for (int j = 0; j < NUM_SLOTS; j++) begin
                if (freed[j] && (code_q[j] < code_q[s])) begin
                    dec = dec + CODE_W'(1);
                end
            end
            if (freed[s] || !occupied[s]) begin
                code_d[s] = '0;
            end else begin
                code_d[s] = code_q[s] - dec;
            end
        end
        if (commit) begin
            code_d[commit_slot] = held_cnt + CODE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) code_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) code_q[s] <= code_d[s];
        end
    end
endmodule

// File: rtl/cec_rx_slot_mem.sv
module cec_rx_slot_mem
    import cec_rx_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int IDX_W = $clog2(MAX_BYTES),
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [LEN_W-1:0]  rd_len
);
    logic [BYTE_W-1:0] slot_byte [NUM_SLOTS];
    logic [LEN_W-1:0]  slot_len  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [BYTE_W-1:0] bytes_q [MAX_BYTES];
        logic [LEN_W-1:0]  len_q;
        logic              sel;

        assign sel = (wr_slot == SLOT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q <= '0;
            end else if (len_we && sel) begin
                len_q <= len_val;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && sel) begin
                bytes_q[wr_idx] <= wr_data;
            end
        end

        assign slot_byte[s] = bytes_q[rd_idx];
        assign slot_len[s]  = len_q;
    end

    always_comb begin
        rd_data = '0;
        rd_len  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_slot == SLOT_W'(s)) begin
                rd_data = slot_byte[s];
                rd_len  = slot_len[s];
            end
        end
    end
endmodule

// File: rtl/cec_rx_frame_store.sv
module cec_rx_frame_store
    import cec_rx_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int IDX_W = $clog2(MAX_BYTES),
    localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_byte,
    input  logic                          in_last,
    input  logic                          in_err,
    input  logic [NUM_SLOTS:0]            buf_ctrl,
    input  logic [NUM_SLOTS-1:0]          addr_en,
    input  logic [NUM_SLOTS*LA_W-1:0]     addr_list,
    input  logic [SLOT_W-1:0]             rd_buf,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [BYTE_W-1:0]             rd_byte,
    output logic [LEN_W-1:0]              rd_len,
    output logic [NUM_SLOTS*CODE_W-1:0]   order_field,
    output logic [NUM_SLOTS-1:0]          ready_irq
);
    rx_state_t state_q, state_d;
    logic [LEN_W-1:0]     cnt_q, cnt_d;
    logic [SLOT_W-1:0]    tgt_q, tgt_d;
    logic [NUM_SLOTS-1:0] clr_q;
    logic [NUM_SLOTS-1:0] release_req;
    logic [NUM_SLOTS-1:0] occupied;
    logic                 multi_mode;
    logic                 hdr_ok;
    logic                 have_free;
    logic [SLOT_W-1:0]    free_slot;
    logic                 wr_en;
    logic [SLOT_W-1:0]    wr_slot;
    logic [IDX_W-1:0]     wr_idx;
    logic                 commit;
    logic [LEN_W-1:0]     commit_len;

    assign multi_mode  = buf_ctrl[NUM_SLOTS];
    assign release_req = clr_q & ~buf_ctrl[NUM_SLOTS-1:0];
    assign ready_irq   = occupied;

    cec_rx_addr_filter #(.NUM_LA(NUM_SLOTS)) u_filter (
        .dest    (in_byte[LA_W-1:0]),
        .la_en   (addr_en),
        .la_list (addr_list),
        .hit     (hdr_ok)
    );

    always_comb begin
        have_free = 1'b0;
        free_slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (!occupied[s] && (multi_mode || s == 0)) begin
                have_free = 1'b1;
                free_slot = SLOT_W'(s);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
            clr_q   <= buf_ctrl[NUM_SLOTS-1:0];
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        tgt_d      = tgt_q;
        wr_en      = 1'b0;
        wr_idx     = '0;
        commit     = 1'b0;
        commit_len = '0;
        wr_slot    = tgt_q;
        unique case (state_q)
            ST_IDLE: begin
                wr_slot = free_slot;
                if (in_valid) begin
                    if (hdr_ok && have_free) begin
                        wr_en = 1'b1;
                        tgt_d = free_slot;
                        if (in_last) begin
                            commit     = !in_err;
                            commit_len = LEN_W'(1);
                        end else begin
                            state_d = ST_FILL;
                            cnt_d   = LEN_W'(1);
                        end
                    end else if (!in_last) begin
                        state_d = ST_SKIP;
                    end
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    if (cnt_q == LEN_W'(MAX_BYTES)) begin
                        state_d = in_last ? ST_IDLE : ST_SKIP;
                    end else begin
                        wr_en  = 1'b1;
                        wr_idx = cnt_q[IDX_W-1:0];
                        cnt_d  = cnt_q + LEN_W'(1);
                        if (in_last) begin
                            state_d    = ST_IDLE;
                            commit     = !in_err;
                            commit_len = cnt_q + LEN_W'(1);
                        end
                    end
                end
            end
            ST_SKIP: begin
                if (in_valid && in_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    cec_rx_slot_mem #(.MAX_BYTES(MAX_BYTES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_idx  (wr_idx),
        .wr_data (in_byte),
        .len_we  (commit),
        .len_val (commit_len),
        .rd_slot (rd_buf),
        .rd_idx  (rd_idx),
        .rd_data (rd_byte),
        .rd_len  (rd_len)
    );

    cec_rx_order_track u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_slot (wr_slot),
        .release_req (release_req),
        .order_field (order_field),
        .occupied    (occupied)
    );
endmodule

// File: rtl/cec_rx_frame_store_chk.sv
module cec_rx_frame_store_chk
    import cec_rx_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_last,
    input logic                        in_err,
    input logic [NUM_SLOTS:0]          buf_ctrl,
    input logic [NUM_SLOTS*CODE_W-1:0] order_field,
    input logic [NUM_SLOTS-1:0]        ready_irq
);
    logic [CODE_W-1:0] c0, c1, c2;
    logic [CODE_W-1:0] nz_cnt, max_code;

    assign c0 = order_field[1:0];
    assign c1 = order_field[3:2];
    assign c2 = order_field[5:4];

    always_comb begin
        nz_cnt   = '0;
        max_code = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (order_field[s*CODE_W +: CODE_W] != '0) nz_cnt = nz_cnt + CODE_W'(1);
            if (order_field[s*CODE_W +: CODE_W] > max_code) max_code = order_field[s*CODE_W +: CODE_W];
        end
    end

    // R2 and R4: age codes are distinct and dense
    assert_order_dense_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_cnt == max_code) &&
        !(c0 != '0 && c0 == c1) && !(c0 != '0 && c0 == c2) && !(c1 != '0 && c1 == c2));

    assert_irq_after_good_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_irq & ~$past(ready_irq)) != '0) |-> $past(in_valid && in_last && !in_err));

    assert_no_irq_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && in_err) |=> ((ready_irq & ~$past(ready_irq)) == '0));

    assert_single_slot_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_ctrl[NUM_SLOTS]) |=> ((ready_irq & ~$past(ready_irq) & 3'b110) == 3'b000));

    assert_release_needs_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ready_irq & $past(ready_irq)
          & ~($past(buf_ctrl[NUM_SLOTS-1:0], 2) & ~$past(buf_ctrl[NUM_SLOTS-1:0]))) == '0));
endmodule

bind cec_rx_frame_store cec_rx_frame_store_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_err      (in_err),
    .buf_ctrl    (buf_ctrl),
    .order_field (order_field),
    .ready_irq   (ready_irq)
);

// File: tb/test_cec_rx_frame_store.sv
module test_cec_rx_frame_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        in_err = 1'b0;
    logic [3:0]  buf_ctrl = 4'b1000;
    logic [2:0]  addr_en = '0;
    logic [11:0] addr_list = '0;
    logic [1:0]  rd_buf = '0;
    logic [3:0]  rd_idx = '0;
    logic [7:0]  rd_byte;
    logic [4:0]  rd_len;
    logic [5:0]  order_field;
    logic [2:0]  ready_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_mem [3][16];
    int         m_len [3];
    int         m_code [3];
    logic [7:0] fb [20];

    always #5 clk = ~clk;

    cec_rx_frame_store i_cec_rx_frame_store (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_err(in_err), .buf_ctrl(buf_ctrl),
        .addr_en(addr_en), .addr_list(addr_list), .rd_buf(rd_buf),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .rd_len(rd_len),
        .order_field(order_field), .ready_irq(ready_irq)
    );

    function automatic logic [5:0] exp_order();
        logic [5:0] v = '0;
        for (int s = 0; s < 3; s++) v[2*s +: 2] = 2'(m_code[s]);
        return v;
    endfunction

    function automatic logic [2:0] exp_irq();
        logic [2:0] v = '0;
        for (int s = 0; s < 3; s++) v[s] = (m_code[s] != 0);
        return v;
    endfunction

    function automatic bit addr_match(logic [3:0] d);
        bit hit = (d == 4'hF);
        for (int k = 0; k < 3; k++) if (addr_en[k] && addr_list[4*k +: 4] == d) hit = 1'b1;
        return hit;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " order"}, int'(order_field), int'(exp_order()));
        chk({tag, " irq"}, int'(ready_irq), int'(exp_irq()));
        for (int s = 0; s < 3; s++) begin
            if (m_code[s] != 0) begin
                rd_buf = 2'(s);
                rd_idx = '0;
                #1;
                chk({tag, " R3 length"}, int'(rd_len), m_len[s]);
                for (int i = 0; i < m_len[s]; i++) begin
                    rd_idx = 4'(i);
                    #1;
                    chk({tag, " R3 byte"}, int'(rd_byte), int'(m_mem[s][i]));
                end
            end
        end
    endtask

    task automatic model_frame(int n, bit err);
        int tgt = -1;
        int cnt = 0;
        if (n > 16 || err || !addr_match(fb[0][3:0])) return;
        for (int s = 2; s >= 0; s--) if (m_code[s] == 0 && (buf_ctrl[3] || s == 0)) tgt = s;
        if (tgt < 0) return;
        for (int s = 0; s < 3; s++) if (m_code[s] != 0) cnt++;
        for (int i = 0; i < n; i++) m_mem[tgt][i] = fb[i];
        m_len[tgt] = n;
        m_code[tgt] = cnt + 1;
    endtask

    task automatic model_release(int b);
        int c = m_code[b];
        if (c == 0) return;
        m_code[b] = 0;
        for (int s = 0; s < 3; s++) if (m_code[s] > c) m_code[s]--;
    endtask

    task automatic send_frame(int n, logic [3:0] dest, bit err, string tag);
        fb[0] = {4'($urandom_range(0, 15)), dest};
        for (int i = 1; i < n; i++) fb[i] = 8'($urandom_range(0, 255));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = fb[i];
            in_last  = (i == n - 1);
            in_err   = err && (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
        model_frame(n, err);
        check_all(tag);
    endtask

    task automatic release_slot(int b, string tag);
        @(negedge clk);
        buf_ctrl[b] = 1'b1;
        @(negedge clk);
        buf_ctrl[b] = 1'b0;
        @(negedge clk);
        model_release(b);
        check_all(tag);
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin
            m_len[s] = 0;
            m_code[s] = 0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 R2 reset");

        addr_en   = 3'b011;
        addr_list = {4'h2, 4'h9, 4'h4};
        buf_ctrl  = 4'b1000;

        send_frame(3, 4'h4, 1'b0, "R6 R9 first frame slot0");
        send_frame(16, 4'hF, 1'b0, "R3 sixteen-byte broadcast");
        send_frame(4, 4'h2, 1'b0, "R6 disabled address");
        send_frame(17, 4'h9, 1'b0, "R8 seventeen bytes");
        send_frame(5, 4'h9, 1'b1, "R8 error flag");
        send_frame(1, 4'h9, 1'b0, "R1 R2 one-byte frame slot2");
        send_frame(2, 4'h4, 1'b0, "R7 all full");
        release_slot(1, "R4 release middle");
        send_frame(2, 4'hF, 1'b0, "R9 refill lowest free");
        release_slot(0, "R4 release oldest");
        release_slot(0, "R4 release empty slot");
        release_slot(1, "R4 release");
        release_slot(2, "R4 release last");

        buf_ctrl[3] = 1'b0;
        send_frame(3, 4'h9, 1'b0, "R5 single mode slot0");
        send_frame(3, 4'h9, 1'b0, "R5 R7 single mode full");
        release_slot(0, "R5 release");
        buf_ctrl[3] = 1'b1;

        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 99);
            if (op < 55) begin
                int n = (op < 5) ? $urandom_range(17, 19) : $urandom_range(1, 16);
                int dsel = $urandom_range(0, 3);
                logic [3:0] d = (dsel == 0) ? 4'hF : (dsel == 1) ? 4'h4 :
                                (dsel == 2) ? 4'h9 : 4'($urandom_range(0, 15));
                send_frame(n, d, ($urandom_range(0, 7) == 0), "R6 R7 R8 random frame");
            end else if (op < 95) begin
                release_slot($urandom_range(0, 2), "R4 random release");
            end else begin
                buf_ctrl[3] = ~buf_ctrl[3];
                @(negedge clk);
                check_all("R5 mode change");
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule